// File: doc/BRIEF.md
# Programmable Parallel Port Register Core

This block sits between a byte-wide processor bus and twenty-four general purpose I/O lines, grouped as two full bytes (port A, port B) and one byte (port C) that is handled as two independent nibbles. Software configures the direction of each port or nibble by writing a single configuration byte to a write-only control location. The same location also accepts a one-bit command that sets or clears one port C output bit without touching the others. Only the simple level-sensitive mode is implemented. Any mode code written is accepted and behaves as that mode.

Each port has an output latch, a per-bit output enable and a read path. A chip-level wrapper combines the latch, the enable and the pin input into tri-state pads. Bus strobes are sampled on the system clock. A write is committed on the clock edge that first sees the write strobe high again after it was low, provided chip select is still low. Read data is registered.

Top module: `ppr_core`

## Requirements
- R1: After the active-high reset, every output latch is 0x00 and every output enable is 0, which means all ports are inputs.
- R2: Register select 00 writes the port A latch, 01 writes the port B latch and 10 writes the full port C latch. A whole byte moves on each access.
- R3: A read with select 11 returns 0x00. The control byte can never be read back.
- R4: A control write with bit 7 = 1 is a configuration word. Bit 4 sets port A, bit 3 sets PC7-PC4, bit 1 sets port B and bit 0 sets PC3-PC0. A direction bit of 1 means input (enables 0), and 0 means output (enables all 1). Each port or nibble is either fully enabled or fully disabled. For example, 0x82 makes port B an input and everything else an output.
- R5: A configuration word clears all three output latches to 0x00.
- R6: A control write with bit 7 = 0 is a bit command. Bits 3:1 select the port C bit (0 to 7) and bit 0 gives its new value. No other latch bit, port or enable changes.
- R7: A read of an input port or nibble returns the live pin value. A read of an output port or nibble returns its latch. Port C is resolved per nibble. Read data appears on `rdata` one clock after the clock edge that samples the read strobe low with chip select low, and it holds when no read is in progress.
- R8: The mode fields of a configuration word (bits 6:5 and bit 2) do not change the behaviour. Words that differ only in those bits give identical enables and read results.
- R9: While chip select is high, no access has any effect. While the write strobe is held low, nothing is committed. Exactly one commit occurs, on the rising edge of the write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe; commits on its rising edge |
| addr | input | 2 | Register select |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Registered read data byte |
| pa_in | input | 8 | Port A pin inputs |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A per-bit output enable |
| pb_in | input | 8 | Port B pin inputs |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B per-bit output enable |
| pc_in | input | 8 | Port C pin inputs |
| pc_out | output | 8 | Port C output latch |
| pc_oe | output | 8 | Port C per-bit output enable |

## Verification
The properties assume the bus follows the strobe discipline: address and write data are stable on the clock edge that sees the write strobe rise, and chip select is still low on that edge. The bit-command property assumes the write data then holds a command with bit 7 clear. The bench drives every bus change on the falling clock edge and keeps chip select, address and data steady across each strobe rise. Pin inputs change only between bus accesses, so each read samples a settled value.

// File: rtl/ppr_pkg.sv
package ppr_pkg;
  typedef enum logic [1:0] {
    SEL_A    = 2'b00,
    SEL_B    = 2'b01,
    SEL_C    = 2'b10,
    SEL_CTRL = 2'b11
  } sel_e;

  // direction flags: 1 = input, 0 = output
  typedef struct packed {
    logic a;
    logic cu;
    logic b;
    logic cl;
  } dir_t;

  localparam int CW_KIND_BIT = 7;
  localparam int CW_DIR_A    = 4;
  localparam int CW_DIR_CU   = 3;
  localparam int CW_DIR_B    = 1;
  localparam int CW_DIR_CL   = 0;
  localparam int CMD_VAL_BIT = 0;
  localparam int CMD_SEL_LO  = 1;

  localparam dir_t DIR_ALL_IN = '{a: 1'b1, cu: 1'b1, b: 1'b1, cl: 1'b1};
endpackage

// File: rtl/ppr_bus_sync.sv
module ppr_bus_sync (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic rd_n,
  input  logic wr_n,
  output logic wr_commit,
  output logic rd_active
);
  logic wr_n_q;

  always_ff @(posedge clk) begin
    if (rst) wr_n_q <= 1'b1;
    else     wr_n_q <= wr_n;
  end

  // rising edge of the write strobe seen with the chip selected
  assign wr_commit = ~cs_n & wr_n & ~wr_n_q;
  assign rd_active = ~cs_n & ~rd_n;
endmodule

// File: rtl/ppr_regs.sv
module ppr_regs
  import ppr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_commit,
  input  logic [1:0]   addr,
  input  logic [W-1:0] wdata,
  output dir_t         dir,
  output logic [W-1:0] pa_lat,
  output logic [W-1:0] pb_lat,
  output logic [W-1:0] pc_lat
);
  localparam int SW = $clog2(W);

  logic wr_a, wr_b, wr_c, wr_cfg, wr_cmd;
  logic [SW-1:0] cmd_sel;

  assign wr_a    = wr_commit && (addr == SEL_A);
  assign wr_b    = wr_commit && (addr == SEL_B);
  assign wr_c    = wr_commit && (addr == SEL_C);
  assign wr_cfg  = wr_commit && (addr == SEL_CTRL) &&  wdata[CW_KIND_BIT];
  assign wr_cmd  = wr_commit && (addr == SEL_CTRL) && !wdata[CW_KIND_BIT];
  assign cmd_sel = wdata[CMD_SEL_LO +: SW];

  always_ff @(posedge clk) begin
    if (rst) begin
      dir <= DIR_ALL_IN;
    end else if (wr_cfg) begin
      dir.a  <= wdata[CW_DIR_A];
      dir.cu <= wdata[CW_DIR_CU];
      dir.b  <= wdata[CW_DIR_B];
      dir.cl <= wdata[CW_DIR_CL];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || wr_cfg) pa_lat <= '0;
    else if (wr_a)     pa_lat <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || wr_cfg) pb_lat <= '0;
    else if (wr_b)     pb_lat <= wdata;
  end

  // port C is handled bit by bit so the bit command needs no read-modify-write
  for (genvar i = 0; i < W; i++) begin : g_pc_bit
    always_ff @(posedge clk) begin
      if (rst || wr_cfg)
        pc_lat[i] <= 1'b0;
      else if (wr_c)
        pc_lat[i] <= wdata[i];
      else if (wr_cmd && (cmd_sel == SW'(i)))
        pc_lat[i] <= wdata[CMD_VAL_BIT];
    end
  end
endmodule

// File: rtl/ppr_rdmux.sv
module ppr_rdmux
  import ppr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rd_active,
  input  logic [1:0]   addr,
  input  dir_t         dir,
  input  logic [W-1:0] pa_lat,
  input  logic [W-1:0] pb_lat,
  input  logic [W-1:0] pc_lat,
  input  logic [W-1:0] pa_in,
  input  logic [W-1:0] pb_in,
  input  logic [W-1:0] pc_in,
  output logic [W-1:0] rdata
);
  localparam int HW = W / 2;

  logic [W-1:0] a_view, b_view, c_view, sel_view;

  assign a_view = dir.a ? pa_in : pa_lat;
  assign b_view = dir.b ? pb_in : pb_lat;
  assign c_view = {dir.cu ? pc_in[W-1:HW] : pc_lat[W-1:HW],
                   dir.cl ? pc_in[HW-1:0] : pc_lat[HW-1:0]};

  always_comb begin
    unique case (sel_e'(addr))
      SEL_A:    sel_view = a_view;
      SEL_B:    sel_view = b_view;
      SEL_C:    sel_view = c_view;
      default:  sel_view = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)            rdata <= '0;
    else if (rd_active) rdata <= sel_view;
  end
endmodule

// File: rtl/ppr_core.sv
module ppr_core
  import ppr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cs_n,
  input  logic         rd_n,
  input  logic         wr_n,
  input  logic [1:0]   addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  input  logic [W-1:0] pa_in,
  output logic [W-1:0] pa_out,
  output logic [W-1:0] pa_oe,
  input  logic [W-1:0] pb_in,
  output logic [W-1:0] pb_out,
  output logic [W-1:0] pb_oe,
  input  logic [W-1:0] pc_in,
  output logic [W-1:0] pc_out,
  output logic [W-1:0] pc_oe
);
  localparam int HW = W / 2;

  logic wr_commit, rd_active;
  dir_t dir;
  logic [W-1:0] pa_lat, pb_lat, pc_lat;

  ppr_bus_sync u_sync (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .wr_commit(wr_commit), .rd_active(rd_active)
  );

  ppr_regs #(.W(W)) u_regs (
    .clk(clk), .rst(rst), .wr_commit(wr_commit), .addr(addr), .wdata(wdata),
    .dir(dir), .pa_lat(pa_lat), .pb_lat(pb_lat), .pc_lat(pc_lat)
  );

  ppr_rdmux #(.W(W)) u_rd (
    .clk(clk), .rst(rst), .rd_active(rd_active), .addr(addr), .dir(dir),
    .pa_lat(pa_lat), .pb_lat(pb_lat), .pc_lat(pc_lat),
    .pa_in(pa_in), .pb_in(pb_in), .pc_in(pc_in), .rdata(rdata)
  );

  assign pa_out = pa_lat;
  assign pb_out = pb_lat;
  assign pc_out = pc_lat;
  assign pa_oe  = {W{~dir.a}};
  assign pb_oe  = {W{~dir.b}};
  assign pc_oe  = {{HW{~dir.cu}}, {HW{~dir.cl}}};
endmodule

// File: rtl/ppr_core_chk.sv
module ppr_core_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         cs_n,
  input logic         rd_n,
  input logic         wr_n,
  input logic [1:0]   addr,
  input logic [W-1:0] wdata,
  input logic [W-1:0] rdata,
  input logic [W-1:0] pa_out,
  input logic [W-1:0] pa_oe,
  input logic [W-1:0] pb_out,
  input logic [W-1:0] pb_oe,
  input logic [W-1:0] pc_out,
  input logic [W-1:0] pc_oe
);
  localparam int HW = W / 2;

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (pa_out == '0 && pb_out == '0 && pc_out == '0 &&
             pa_oe == '0 && pb_oe == '0 && pc_oe == '0));

  // R3
  ctrl_unreadable_chk: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !rd_n && addr == 2'b11) |=> (rdata == '0));

  // R4
  oe_uniform_chk: assert property (@(posedge clk) disable iff (rst)
    ((pa_oe == '0) || (pa_oe == '1)) && ((pb_oe == '0) || (pb_oe == '1)) &&
    ((pc_oe[W-1:HW] == '0) || (pc_oe[W-1:HW] == '1)) &&
    ((pc_oe[HW-1:0] == '0) || (pc_oe[HW-1:0] == '1)));

  // R5
  cfg_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && wr_n && $past(!wr_n) && addr == 2'b11 && wdata[7])
    |=> (pa_out == '0 && pb_out == '0 && pc_out == '0));

  // R6
  bit_cmd_single_chk: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && wr_n && $past(!wr_n) && addr == 2'b11 && !wdata[7])
    |=> ($stable(pa_out) && $stable(pb_out) && $stable(pa_oe) &&
         $stable(pb_oe) && $stable(pc_oe) &&
         $countones(pc_out ^ $past(pc_out)) <= 1));

  // R9
  deselect_hold_chk: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> ($stable(pa_out) && $stable(pb_out) && $stable(pc_out) &&
              $stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe)));

  // R9
  strobe_low_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_n |=> ($stable(pa_out) && $stable(pb_out) && $stable(pc_out) &&
               $stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe)));
endmodule

bind ppr_core ppr_core_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
  .wdata(wdata), .rdata(rdata), .pa_out(pa_out), .pa_oe(pa_oe),
  .pb_out(pb_out), .pb_oe(pb_oe), .pc_out(pc_out), .pc_oe(pc_oe)
);

// File: tb/ppr_core_test.sv
module ppr_core_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0] addr = 2'b00;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'h00;
  logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  ppr_core uut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
    .wdata(wdata), .rdata(rdata),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); cs_n = 1'b0; addr = a; wdata = d; wr_n = 1'b0;
    @(negedge clk); wr_n = 1'b1;
    @(negedge clk); cs_n = 1'b1;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); cs_n = 1'b0; rd_n = 1'b0; addr = a;
    @(negedge clk); d = rdata; rd_n = 1'b1; cs_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    logic [7:0] model_c;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    check("R1 latches", {pa_out, pb_out, pc_out}, 24'h0);
    check("R1 enables", {pa_oe, pb_oe, pc_oe}, 24'h0);
    pa_in = 8'h3C;
    bus_read(2'b00, rd);
    check("R1 port A reads pins", rd, 8'h3C);

    // R3: control location is unreadable
    bus_write(2'b11, 8'h80);
    bus_read(2'b11, rd);
    check("R3 control read", rd, 8'h00);

    // R4: worked example 0x82
    bus_write(2'b11, 8'h82);
    check("R4 0x82 enables", {pa_oe, pb_oe, pc_oe}, 24'hFF00FF);

    // R4 R5 R7 R8 R2: sweep every configuration word
    for (int m = 128; m < 256; m++) begin
      logic [7:0] cw, ea, eb, ec, av, bv, cv;
      cw = 8'(m);
      bus_write(2'b11, cw);
      ea = cw[4] ? 8'h00 : 8'hFF;
      eb = cw[1] ? 8'h00 : 8'hFF;
      ec = {cw[3] ? 4'h0 : 4'hF, cw[0] ? 4'h0 : 4'hF};
      check("R4 R8 enables", {pa_oe, pb_oe, pc_oe}, {ea, eb, ec});
      check("R5 latches cleared", {pa_out, pb_out, pc_out}, 24'h0);
      av = 8'(m * 7 + 1);
      bv = 8'(m * 13 + 5);
      cv = 8'(m * 29 + 11);
      bus_write(2'b00, av);
      bus_write(2'b01, bv);
      bus_write(2'b10, cv);
      check("R2 latches", {pa_out, pb_out, pc_out}, {av, bv, cv});
      pa_in = ~av; pb_in = bv ^ 8'h5A; pc_in = ~cv;
      bus_read(2'b00, rd);
      check("R7 R8 read A", rd, cw[4] ? pa_in : av);
      bus_read(2'b01, rd);
      check("R7 R8 read B", rd, cw[1] ? pb_in : bv);
      bus_read(2'b10, rd);
      check("R7 R8 read C", rd, {cw[3] ? pc_in[7:4] : cv[7:4], cw[0] ? pc_in[3:0] : cv[3:0]});
    end

    // R6: every bit command from a known port C pattern
    bus_write(2'b11, 8'h80);
    bus_write(2'b00, 8'h11);
    bus_write(2'b01, 8'h22);
    bus_write(2'b10, 8'h5A);
    model_c = 8'h5A;
    for (int k = 0; k < 16; k++) begin
      bus_write(2'b11, 8'(k));
      model_c[k >> 1] = k[0];
      check("R6 port C bit", pc_out, model_c);
      check("R6 others intact", {pa_out, pb_out, pa_oe, pb_oe, pc_oe}, 40'h1122FFFFFF);
    end

    // R9: write with chip deselected is ignored
    @(negedge clk); addr = 2'b00; wdata = 8'hE7; wr_n = 1'b0;
    @(negedge clk); wr_n = 1'b1;
    @(negedge clk);
    check("R9 deselected write", pa_out, 8'h11);

    // R9: strobe held low commits nothing until it rises
    @(negedge clk); cs_n = 1'b0; addr = 2'b00; wdata = 8'hC3; wr_n = 1'b0;
    repeat (4) @(negedge clk);
    check("R9 strobe held low", pa_out, 8'h11);
    wr_n = 1'b1;
    @(negedge clk); cs_n = 1'b1;
    check("R9 commit on rise", pa_out, 8'hC3);

    // R7: rdata holds after the read ends
    bus_read(2'b01, rd);
    pb_in = 8'h00;
    repeat (2) @(negedge clk);
    check("R7 rdata hold", rdata, 8'h22);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule